// File: doc/BRIEF.md
# Serial ID CRC-8 checker

This block checks a 64-bit identification word that arrives one bit per strobe, least significant bit first. A start strobe arms the checker and clears its state. The first 56 accepted bits run through an 8-bit CRC with the generator x^8 + x^5 + x^4 + 1. The last 8 bits are gathered into a separate check byte, and that byte takes no part in the CRC.

When the 64th bit is taken, the block raises a one-cycle done pulse. At the same time it sets a match flag when the computed CRC equals the gathered check byte. The check byte is compared in true form, with no inversion. The computed CRC byte is visible at all times. Bit strobes that arrive while the checker is not armed are ignored. This covers strobes after a word has completed and before the next start, and strobes after reset before any start.

Top module: `idcrc_check`

## Requirements
- R1: After reset, done_o and match_o are 0, crc_o is 8'h00, and the checker is not armed.
- R2: A start strobe arms the checker. On the next cycle crc_o is 8'h00 and done_o and match_o are 0. A start in the middle of a word abandons that word and begins a new one.
- R3: Each of the first 56 accepted bits updates the CRC by these steps: feedback = crc[0] XOR bit, crc = crc >> 1, and if feedback is 1, crc ^= 8'h8C. Bits are taken LSB first, so the word 02 1C B8 01 00 00 00 (low byte first) gives 8'hA2.
- R4: Bits 56 to 63 do not change crc_o.
- R5: Bits 56 to 63 form the check byte, with bit 56 as its LSB and bit 63 as its MSB.
- R6: done_o is 1 for exactly one cycle, namely the cycle after the clock edge that accepts bit 63.
- R7: With done_o, match_o is 1 exactly when crc_o equals the check byte, with no inversion. match_o then holds until the next start.
- R8: While the checker is not armed (after a word completes, or after reset before any start), bit strobes change nothing: crc_o and match_o stay put and done_o stays 0.
- R9: If start and a bit strobe come in the same cycle, start wins and that bit is discarded.
- R10: Idle cycles between bit strobes do not affect the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Arms the checker and clears its state |
| bit_valid_i | input | 1 | Marks bit_i as valid this cycle |
| bit_i | input | 1 | Serial identification bit, LSB first |
| done_o | output | 1 | One-cycle pulse after the 64th bit |
| match_o | output | 1 | Computed CRC equals the check byte |
| crc_o | output | 8 | Running or final computed CRC |

## Verification
Four kinds of words are used:
- The all-zero word gives a CRC of zero.
- A known published word must produce 8'hA2. This separates a reflected shift from a left shift and a wrong tap mask.
- Words with a correct check byte are contrasted with words that have a flipped data bit or a wrong check byte, which separates a real comparison from a constant flag.
- A check byte sent with its bits reversed catches a wrong gathering order.

Further runs cover the following cases:
- Gaps between strobes.
- Strobes before any start and after completion.
- A restart in mid-word.
- Start arriving together with a strobe.

These runs show that the bit count and the arming logic accept exactly the intended 64 bits.

// File: rtl/idcrc_pkg.sv
package idcrc_pkg;
  localparam int         CRC_W     = 8;
  localparam logic [7:0] POLY_REFL = 8'h8C;  // x^8+x^5+x^4+1, reflected

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_BODY,
    PH_TAIL
  } phase_e;
endpackage

// File: rtl/idcrc_seq.sv
module idcrc_seq
  import idcrc_pkg::*;
#(
  parameter int ID_BITS = 64,
  parameter int CHK_W   = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic valid_i,
  output logic take_body_o,
  output logic take_tail_o,
  output logic take_last_o
);
  localparam int DATA_BITS = ID_BITS - CHK_W;
  localparam int CW        = $clog2(ID_BITS);

  phase_e        ph_q;
  logic [CW-1:0] cnt_q;

  assign take_body_o = valid_i && !start_i && (ph_q == PH_BODY);
  assign take_tail_o = valid_i && !start_i && (ph_q == PH_TAIL);
  assign take_last_o = take_tail_o && (cnt_q == CW'(ID_BITS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else if (start_i) begin
      ph_q  <= PH_BODY;
      cnt_q <= '0;
    end else if (take_body_o) begin
      cnt_q <= cnt_q + CW'(1);
      if (cnt_q == CW'(DATA_BITS - 1)) ph_q <= PH_TAIL;
    end else if (take_tail_o) begin
      if (take_last_o) begin
        ph_q  <= PH_IDLE;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  AST_SINGLE_TAKE: assert property (@(posedge clk) disable iff (rst)
    $countones({take_body_o, take_tail_o}) <= 1); // R5
endmodule

// File: rtl/idcrc_lfsr.sv
module idcrc_lfsr #(
  parameter int             W    = 8,
  parameter logic [W-1:0]   MASK = 8'h8C
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] crc_o
);
  logic [W-1:0] crc_q;
  logic [W-1:0] crc_nxt;
  logic         fb;

  assign fb = crc_q[0] ^ bit_i;

  for (genvar i = 0; i < W; i++) begin : g_tap
    if (i == W - 1) begin : g_top
      assign crc_nxt[i] = fb & MASK[i];
    end else begin : g_mid
      assign crc_nxt[i] = crc_q[i+1] ^ (fb & MASK[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) crc_q <= '0;
    else if (en_i)    crc_q <= crc_nxt;
  end

  assign crc_o = crc_q;

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (crc_o == '0)); // R2
endmodule

// File: rtl/idcrc_tail.sv
module idcrc_tail #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] nxt_o
);
  logic [W-1:0] byte_q;

  assign nxt_o = {bit_i, byte_q[W-1:1]};

  always_ff @(posedge clk) begin
    if (rst || clr_i) byte_q <= '0;
    else if (en_i)    byte_q <= nxt_o;
  end
endmodule

// File: rtl/idcrc_check.sv
module idcrc_check
  import idcrc_pkg::*;
#(
  parameter int                 ID_BITS = 64,
  parameter int                 CHK_W   = CRC_W,
  parameter logic [CHK_W-1:0]   POLY    = POLY_REFL
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             bit_valid_i,
  input  logic             bit_i,
  output logic             done_o,
  output logic             match_o,
  output logic [CHK_W-1:0] crc_o
);
  logic             take_body;
  logic             take_tail;
  logic             take_last;
  logic [CHK_W-1:0] chk_nxt;
  logic             done_q;
  logic             match_q;

  idcrc_seq #(.ID_BITS(ID_BITS), .CHK_W(CHK_W)) u_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .valid_i(bit_valid_i),
    .take_body_o(take_body), .take_tail_o(take_tail), .take_last_o(take_last)
  );

  idcrc_lfsr #(.W(CHK_W), .MASK(POLY)) u_lfsr (
    .clk(clk), .rst(rst), .clr_i(start_i), .en_i(take_body),
    .bit_i(bit_i), .crc_o(crc_o)
  );

  idcrc_tail #(.W(CHK_W)) u_tail (
    .clk(clk), .rst(rst), .clr_i(start_i), .en_i(take_tail),
    .bit_i(bit_i), .nxt_o(chk_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst || start_i) begin
      done_q  <= 1'b0;
      match_q <= 1'b0;
    end else begin
      done_q <= take_last;
      if (take_last) match_q <= (crc_o == chk_nxt);
    end
  end

  assign done_o  = done_q;
  assign match_o = match_q;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R6
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (crc_o == '0 && !done_o && !match_o)); // R2
  AST_TAIL_CRC_FROZEN: assert property (@(posedge clk) disable iff (rst)
    take_tail |=> $stable(crc_o)); // R4
  AST_MATCH_STEADY: assert property (@(posedge clk) disable iff (rst)
    (!start_i && !take_last) |=> $stable(match_o)); // R7
  AST_IGNORED_STROBE: assert property (@(posedge clk) disable iff (rst)
    (!start_i && !take_body) |=> $stable(crc_o)); // R8
endmodule

// File: tb/idcrc_check_test.sv
module idcrc_check_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic       bit_valid_i = 1'b0;
  logic       bit_i = 1'b0;
  logic       done_o;
  logic       match_o;
  logic [7:0] crc_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  idcrc_check uut (
    .clk(clk), .rst(rst), .start_i(start_i), .bit_valid_i(bit_valid_i),
    .bit_i(bit_i), .done_o(done_o), .match_o(match_o), .crc_o(crc_o)
  );

  function automatic logic [7:0] ref_crc(logic [55:0] d);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < 56; i++) begin
      logic fb = c[0] ^ d[i];
      c = c >> 1;
      if (fb) c = c ^ 8'h8C;
    end
    return c;
  endfunction

  function automatic logic [63:0] good_id(logic [55:0] d);
    return {ref_crc(d), d};
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic send_bit(logic b, int gap);
    @(negedge clk) begin bit_valid_i = 1'b1; bit_i = b; end
    @(negedge clk) bit_valid_i = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  // Sends bits lo..hi; the last bit of a full word goes out with no gap.
  task automatic send_bits(logic [63:0] id, int lo, int hi, int gap);
    for (int i = lo; i <= hi; i++) send_bit(id[i], (i == 63) ? 0 : gap);
  endtask

  // Called right after bit 63: done visible now, gone next cycle.
  task automatic verify(string req, logic [63:0] id, logic exp_m);
    chk({req, " R6 done"}, {7'd0, done_o}, 8'd1);
    chk({req, " R7 match"}, {7'd0, match_o}, {7'd0, exp_m});
    chk({req, " R3 crc"}, crc_o, ref_crc(id[55:0]));
    @(negedge clk);
    chk({req, " R6 pulse"}, {7'd0, done_o}, 8'd0);
    repeat (3) @(negedge clk);
    chk({req, " R7 hold"}, {7'd0, match_o}, {7'd0, exp_m});
  endtask

  task automatic run_word(string req, logic [63:0] id, int gap, logic exp_m);
    pulse_start();
    send_bits(id, 0, 63, gap);
    verify(req, id, exp_m);
  endtask

  task automatic t_reset();
    chk("R1 done", {7'd0, done_o}, 8'd0);
    chk("R1 match", {7'd0, match_o}, 8'd0);
    chk("R1 crc", crc_o, 8'h00);
  endtask

  task automatic t_before_start();
    for (int i = 0; i < 10; i++) send_bit(1'b1, 0);
    chk("R8 crc before start", crc_o, 8'h00);
    chk("R8 no done before start", {7'd0, done_o}, 8'd0);
  endtask

  task automatic t_known();
    logic [63:0] id = {8'hA2, 56'h000000_01B81C02};
    chk("R3 reference A2", ref_crc(id[55:0]), 8'hA2);
    run_word("R3 known", id, 0, 1'b1);
  endtask

  task automatic t_patterns();
    run_word("R3 zero", 64'h0, 0, 1'b1);
    run_word("R3 ones", good_id(56'hFF_FFFF_FFFF_FFFF), 0, 1'b1);
    run_word("R3 mixed", good_id(56'h5A_C3E1_0F96_2D47), 0, 1'b1);
  endtask

  task automatic t_mismatch();
    logic [63:0] id = good_id(56'h12_3456_789A_BCDE);
    run_word("R7 bad check", id ^ 64'h0100_0000_0000_0000, 0, 1'b0);
    run_word("R7 bad data", id ^ 64'h0000_0000_0010_0000, 0, 1'b0);
    run_word("R7 inverted", {~id[63:56], id[55:0]}, 0, 1'b0);
  endtask

  task automatic t_order();
    logic [63:0] id = {8'hA2, 56'h000000_01B81C02};
    logic [7:0]  rev;
    for (int i = 0; i < 8; i++) rev[i] = id[63-i];
    run_word("R5 reversed byte", {rev, id[55:0]}, 0, 1'b0);
  endtask

  task automatic t_tail_frozen();
    logic [63:0] id = good_id(56'hA5_5A00_FF13_7C21);
    pulse_start();
    send_bits(id, 0, 55, 0);
    chk("R4 crc after body", crc_o, ref_crc(id[55:0]));
    send_bits(id, 56, 60, 1);
    chk("R4 crc during tail", crc_o, ref_crc(id[55:0]));
    send_bits(id, 61, 63, 0);
    verify("R4 tail", id, 1'b1);
  endtask

  task automatic t_after_done();
    logic [63:0] id = good_id(56'h00_0000_0000_0001);
    logic [7:0] c = ref_crc(id[55:0]);
    run_word("R8 base", id, 0, 1'b1);
    for (int i = 0; i < 5; i++) begin
      send_bit(i[0], 0);
      chk("R8 no done", {7'd0, done_o}, 8'd0);
    end
    chk("R8 crc kept", crc_o, c);
    chk("R8 match kept", {7'd0, match_o}, 8'd1);
  endtask

  task automatic t_restart();
    logic [63:0] id = good_id(56'h77_0102_0304_0506);
    pulse_start();
    for (int i = 0; i < 20; i++) send_bit(1'b1, 0);
    run_word("R2 restart", id, 0, 1'b1);
  endtask

  task automatic t_start_with_bit();
    logic [63:0] id = good_id(56'h3C_9988_7766_5544);
    @(negedge clk) begin start_i = 1'b1; bit_valid_i = 1'b1; bit_i = 1'b1; end
    @(negedge clk) begin start_i = 1'b0; bit_valid_i = 1'b0; end
    chk("R9 crc clear", crc_o, 8'h00);
    send_bits(id, 0, 63, 0);
    verify("R9 start wins", id, 1'b1);
  endtask

  task automatic t_gaps();
    run_word("R10 gaps", good_id(56'hDE_ADBE_EF01_2345), 2, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_before_start();
    t_known();
    t_patterns();
    t_mismatch();
    t_order();
    t_tail_frozen();
    t_after_done();
    t_restart();
    t_start_with_bit();
    t_gaps();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule